// File: doc/BRIEF.md
# Circular Capture Buffer Controller

This block manages sample storage for an on-chip logic analyzer. Once armed, it writes the probe bus into a ring memory on every sample clock, and the newest sample replaces the oldest. When a trigger pulse arrives, it records the physical slot of the trigger sample. It then stores a fixed number of further samples, set by the trigger-position mode, and stops. A continuous mode keeps recording through the trigger until a stop command arrives. A stop command also ends a capture early in any mode.

After capture ends, a host reads the buffer in time order. The read address is an offset from the oldest valid sample, and the block wraps it around the ring. The block reports how many samples are valid, so a trigger that comes before the ring has filled gives a shorter record and never exposes stale data. The physical slots of the oldest sample and of the trigger sample are exported, and their difference places the trigger within the record. DEPTH must be a power of two and at least 16. Trigger evaluation and host transport are handled elsewhere.

Top module: `capture_ring_ctrl`

## Requirements
- R1: After reset, capRunning, capDone and trigSeen are 0 and validCount is 0.
- R2: An armIn pulse sets the write slot to 0 and validCount to 0, and starts recording. On every later clock edge while capRunning is high, probeIn is written to the next slot. validCount rises by one per write and saturates at DEPTH, and the newest sample overwrites the oldest.
- R3: With modeSel=0 latched at arm, capture stops after floor(DEPTH*88/100) writes, counting the write made on the trigger edge as the first.
- R4: With modeSel=1, capture stops after DEPTH/2 writes, counting from the trigger write.
- R5: With modeSel=2, capture stops after floor(DEPTH*12/100) writes, counting from the trigger write.
- R6: With modeSel=3, a trigger is recorded but writing continues. A stopIn pulse ends capture in any mode, and no write occurs on that edge.
- R7: capDone rises on the edge after the last write and stays high until the next arm. While capDone is high, probeIn, trigIn and stopIn change neither the stored data nor validCount.
- R8: rdData gives the sample at time-ordered offset rdAddr from the oldest valid sample, wrapping modulo DEPTH. rdData is 0 when rdAddr >= validCount.
- R9: oldestAddr is the physical slot of the oldest valid sample, equal to (write slot - validCount) mod DEPTH. trigAddr holds the physical slot of the trigger sample, so the trigger's offset in the record is (trigAddr - oldestAddr) mod DEPTH.
- R10: modeSel is sampled only on the arm edge, so later changes during a capture have no effect.
- R11: Only the first trigger after arm is taken. Later trigger pulses change neither trigAddr nor the stop point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armIn | input | 1 | Start a new capture |
| stopIn | input | 1 | End the capture now |
| trigIn | input | 1 | Trigger event pulse |
| modeSel | input | 2 | 0 early, 1 center, 2 late, 3 continuous |
| probeIn | input | DATA_W | Probe bus sample |
| rdAddr | input | ADDR_W | Readout offset from the oldest sample |
| rdData | output | DATA_W | Readout sample |
| capRunning | output | 1 | Capture in progress |
| capDone | output | 1 | Capture finished |
| trigSeen | output | 1 | Trigger taken in this capture |
| trigAddr | output | ADDR_W | Physical slot of the trigger sample |
| oldestAddr | output | ADDR_W | Physical slot of the oldest valid sample |
| validCount | output | ADDR_W+1 | Number of valid stored samples |

## Verification
A wrong post-trigger counter shows at the ports as capDone rising one or more edges early or late. It also moves the trigger offset away from the value the mode predicts, and the bench sees this as soon as the capture ends. A stale write slot or fill count shows as oldestAddr or validCount out of step with the number of edges driven, and as readout returning the wrong tagged sample or a non-zero value past the valid region. A trigger slot that is latched again shows as trigAddr moving after a second pulse, which is checked right after capture stops.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

  typedef enum logic [1:0] {
    MODE_EARLY  = 2'd0,
    MODE_CENTER = 2'd1,
    MODE_LATE   = 2'd2,
    MODE_CONT   = 2'd3
  } capMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic wrEn;
    logic latchTrig;
  } ringCtl_t;

  function automatic int postShare(input int depth, input int pct);
    return (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/cap_ring_fsm.sv
module cap_ring_fsm
  import cap_ring_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       stopIn,
  input  logic       trigIn,
  input  logic [1:0] modeSel,
  output ringCtl_t   ctl,
  output logic       running,
  output logic       capDone,
  output logic       trigSeen
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] POST_EARLY  = CNT_W'(postShare(DEPTH, 88));
  localparam logic [CNT_W-1:0] POST_CENTER = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] POST_LATE   = CNT_W'(postShare(DEPTH, 12));

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  st_e             stateQ;
  capMode_e        modeQ;
  logic            trigSeenQ;
  logic [CNT_W-1:0] remQ;
  logic [CNT_W-1:0] postLoad;
  logic            trigHit;
  logic            lastWrite;

  always_comb begin
    unique case (modeQ)
      MODE_EARLY:  postLoad = POST_EARLY;
      MODE_CENTER: postLoad = POST_CENTER;
      MODE_LATE:   postLoad = POST_LATE;
      default:     postLoad = POST_CENTER;
    endcase
  end

  assign running       = (stateQ == ST_RUN);
  assign capDone       = (stateQ == ST_DONE);
  assign trigSeen      = trigSeenQ;
  assign ctl.clear     = armIn;
  assign ctl.wrEn      = running && !stopIn && !armIn;
  assign trigHit       = ctl.wrEn && trigIn && !trigSeenQ;
  assign ctl.latchTrig = trigHit;
  assign lastWrite     = ctl.wrEn && (modeQ != MODE_CONT) &&
                         ((trigHit && postLoad == CNT_W'(1)) ||
                          (trigSeenQ && remQ == CNT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      modeQ     <= MODE_EARLY;
      trigSeenQ <= 1'b0;
      remQ      <= '0;
    end else if (armIn) begin
      stateQ    <= ST_RUN;
      modeQ     <= capMode_e'(modeSel);
      trigSeenQ <= 1'b0;
      remQ      <= '0;
    end else if (running) begin
      if (stopIn) begin
        stateQ <= ST_DONE;
      end else begin
        if (trigHit) begin
          trigSeenQ <= 1'b1;
          remQ      <= postLoad - CNT_W'(1);
        end else if (trigSeenQ && modeQ != MODE_CONT) begin
          remQ <= remQ - CNT_W'(1);
        end
        if (lastWrite) stateQ <= ST_DONE;
      end
    end
  end

  // R7: finished capture stays finished until re-armed
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    capDone && !armIn |=> capDone);

  // R3: exhausted post count ends the capture on the next edge
  a_r3_post_exhausted: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn && trigSeenQ && remQ == CNT_W'(1) && modeQ != MODE_CONT |=> capDone);

  // R6: continuous mode never stops by itself
  a_r6_cont_keeps_running: assert property (@(posedge clk) disable iff (!rstN)
    running && modeQ == MODE_CONT && !stopIn && !armIn |=> running);

  // R11: a taken trigger is kept for the rest of the capture
  a_r11_trig_sticky: assert property (@(posedge clk) disable iff (!rstN)
    trigSeenQ && !armIn |=> trigSeenQ);

endmodule

// File: rtl/cap_ring_store.sv
module cap_ring_store
  import cap_ring_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCtl_t          ctl,
  input  logic [DATA_W-1:0] probeIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] oldestAddr,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [ADDR_W:0]   validCount
);
  localparam logic [ADDR_W:0] FULL = (ADDR_W + 1)'(DEPTH);

  logic [DATA_W-1:0] ringMem [DEPTH];
  logic [ADDR_W-1:0] wrPtrQ;
  logic [ADDR_W-1:0] trigAddrQ;
  logic [ADDR_W:0]   fillQ;
  logic [ADDR_W-1:0] physRd;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) ringMem[wrPtrQ] <= probeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ    <= '0;
      fillQ     <= '0;
      trigAddrQ <= '0;
    end else if (ctl.clear) begin
      wrPtrQ    <= '0;
      fillQ     <= '0;
      trigAddrQ <= '0;
    end else if (ctl.wrEn) begin
      wrPtrQ <= wrPtrQ + ADDR_W'(1);
      if (fillQ != FULL) fillQ <= fillQ + (ADDR_W + 1)'(1);
      if (ctl.latchTrig) trigAddrQ <= wrPtrQ;
    end
  end

  assign oldestAddr = wrPtrQ - fillQ[ADDR_W-1:0];
  assign physRd     = oldestAddr + rdAddr;
  assign rdData     = ({1'b0, rdAddr} < fillQ) ? ringMem[physRd] : '0;
  assign trigAddr   = trigAddrQ;
  assign validCount = fillQ;

  // R2: fill never exceeds the ring size
  a_r2_fill_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fillQ <= FULL);

  // R2: each write below full grows the fill by one
  a_r2_fill_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn && !ctl.clear && fillQ != FULL |=> fillQ == $past(fillQ) + 1'b1);

  // R7: write slot frozen without a write strobe
  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrEn && !ctl.clear |=> $stable(wrPtrQ));

  // R9: trigger slot only moves on a latch strobe
  a_r9_trig_kept: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchTrig && !ctl.clear |=> $stable(trigAddrQ));

endmodule

// File: rtl/capture_ring_ctrl.sv
module capture_ring_ctrl
  import cap_ring_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armIn,
  input  logic              stopIn,
  input  logic              trigIn,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] probeIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              capRunning,
  output logic              capDone,
  output logic              trigSeen,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [ADDR_W-1:0] oldestAddr,
  output logic [ADDR_W:0]   validCount
);
  ringCtl_t ctl;

  cap_ring_fsm #(.DEPTH(DEPTH)) uFsm (
    .clk(clk), .rstN(rstN), .armIn(armIn), .stopIn(stopIn), .trigIn(trigIn),
    .modeSel(modeSel), .ctl(ctl), .running(capRunning), .capDone(capDone),
    .trigSeen(trigSeen)
  );

  cap_ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .probeIn(probeIn), .rdAddr(rdAddr),
    .rdData(rdData), .oldestAddr(oldestAddr), .trigAddr(trigAddr),
    .validCount(validCount)
  );

endmodule

// File: tb/tb_capture_ring_ctrl.sv
module tb_capture_ring_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEP = 64;
  localparam int AW = 6;

  logic clk = 0, rstN = 0, armIn = 0, stopIn = 0, trigIn = 0;
  logic [1:0] modeSel = 0;
  logic [DW-1:0] probeIn = 0;
  logic [AW-1:0] rdAddr = 0;
  logic [DW-1:0] rdData;
  logic capRunning, capDone, trigSeen;
  logic [AW-1:0] trigAddr, oldestAddr;
  logic [AW:0] validCount;

  int checks = 0, failures = 0;
  bit finished = 0;

  capture_ring_ctrl #(.DATA_W(DW), .DEPTH(DEP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] mode; int preN; int expTotal; int expValid; int expOff;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 20, 76, 64, 8},
    '{2'd0, 3, 59, 59, 3},
    '{2'd1, 40, 72, 64, 32},
    '{2'd1, 10, 42, 42, 10},
    '{2'd2, 100, 107, 64, 57},
    '{2'd2, 0, 7, 7, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readAt(input int off, output int val);
    rdAddr = AW'(off);
    #1 val = int'(rdData);
  endtask

  task automatic armWith(input logic [1:0] m);
    @(negedge clk); modeSel = m; armIn = 1;
    @(negedge clk); armIn = 0;
  endtask

  // drive preN samples, a trigger sample, then samples until capDone
  task automatic runCap(input logic [1:0] m, input int preN, input logic [DW-1:0] base,
                        input bit twoTrig, input bit flipMode, output int n);
    armWith(m);
    if (flipMode) modeSel = 2'd0;
    for (int i = 0; i < preN; i++) begin
      probeIn = base + DW'(i); @(negedge clk);
    end
    probeIn = base + DW'(preN); trigIn = 1; @(negedge clk);
    trigIn = twoTrig;
    n = preN + 1;
    for (int k = 0; k < 300 && !capDone; k++) begin
      probeIn = base + DW'(n); n++; @(negedge clk);
      trigIn = 0;
    end
    trigIn = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, v, v2;
    logic [DW-1:0] base;
    string req;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(capRunning == 0, "R1 running", capRunning, 0);
    check(capDone == 0, "R1 done", capDone, 0);
    check(trigSeen == 0, "R1 trigSeen", trigSeen, 0);
    check(validCount == 0, "R1 validCount", validCount, 0);
    rstN = 1;
    @(negedge clk);
    readAt(0, v);
    check(v == 0, "R8 empty read", v, 0);

    foreach (VECS[i]) begin
      base = DW'(16'h1000 * (i + 1));
      req = (VECS[i].mode == 0) ? "R3" : (VECS[i].mode == 1) ? "R4" : "R5";
      runCap(VECS[i].mode, VECS[i].preN, base, 0, 0, n);
      check(n == VECS[i].expTotal, {req, " write count"}, n, VECS[i].expTotal);
      check(capDone == 1, "R7 done set", capDone, 1);
      check(int'(validCount) == VECS[i].expValid, "R2 validCount", validCount, VECS[i].expValid);
      check(int'(AW'(trigAddr - oldestAddr)) == VECS[i].expOff, "R9 trig offset",
            AW'(trigAddr - oldestAddr), VECS[i].expOff);
      readAt(0, v);
      check(v == int'(base) + VECS[i].expTotal - VECS[i].expValid, "R8 oldest", v,
            int'(base) + VECS[i].expTotal - VECS[i].expValid);
      readAt(VECS[i].expOff, v);
      check(v == int'(base) + VECS[i].preN, "R9 trigger sample", v, int'(base) + VECS[i].preN);
      readAt(VECS[i].expValid - 1, v);
      check(v == int'(base) + VECS[i].expTotal - 1, "R8 newest", v, int'(base) + VECS[i].expTotal - 1);
      if (VECS[i].expValid < DEP) begin
        readAt(VECS[i].expValid, v2);
        check(v2 == 0, "R8 past valid", v2, 0);
      end
      // R7: inputs ignored while done
      for (int k = 0; k < 5; k++) begin
        probeIn = 16'hDEAD; trigIn = k[0]; stopIn = k[1]; @(negedge clk);
      end
      trigIn = 0; stopIn = 0;
      readAt(VECS[i].expValid - 1, v2);
      check(v2 == v, "R7 data frozen", v2, v);
      check(int'(validCount) == VECS[i].expValid, "R7 count frozen", validCount, VECS[i].expValid);
      check(capDone == 1, "R7 done held", capDone, 1);
    end

    // R6 continuous mode: runs through trigger until stop
    base = 16'h7000;
    armWith(2'd3);
    for (int i = 0; i < 91; i++) begin
      probeIn = base + DW'(i); trigIn = (i == 10); @(negedge clk);
    end
    trigIn = 0;
    check(capRunning == 1, "R6 still running", capRunning, 1);
    probeIn = 16'hBEEF; stopIn = 1; @(negedge clk); stopIn = 0;
    check(capDone == 1, "R6 stopped", capDone, 1);
    check(trigSeen == 1, "R6 trigSeen", trigSeen, 1);
    check(trigAddr == 10, "R9 cont trigAddr", trigAddr, 10);
    check(oldestAddr == 27, "R9 cont oldest", oldestAddr, 27);
    readAt(0, v);
    check(v == 16'h7000 + 27, "R2 overwrite oldest", v, 16'h7000 + 27);
    readAt(63, v);
    check(v == 16'h7000 + 90, "R6 no write on stop", v, 16'h7000 + 90);

    // R10 mode latched at arm; R11 second trigger ignored
    base = 16'h8000;
    runCap(2'd2, 5, base, 1, 1, n);
    check(n == 12, "R10 late count kept", n, 12);
    check(trigAddr == 5, "R11 first trigger kept", trigAddr, 5);

    // R6 stop before any trigger in center mode
    armWith(2'd1);
    for (int i = 0; i < 5; i++) begin
      probeIn = DW'(16'h9000 + i); @(negedge clk);
    end
    stopIn = 1; @(negedge clk); stopIn = 0;
    check(capDone == 1, "R6 early stop done", capDone, 1);
    check(trigSeen == 0, "R6 early stop no trig", trigSeen, 0);
    check(validCount == 5, "R6 early stop count", validCount, 5);

    // R2 re-arm clears
    armWith(2'd0);
    check(validCount == 0 && capRunning == 1, "R2 rearm clear", validCount, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule